// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Gating

This block derives the card-side bus clock from the controller's master clock. A 17-bit control word, written through a one-cycle write strobe, chooses the division ratio, switches the output on or off, and can ask the block to park the clock on its own whenever the transfer engine reports an idle bus. Ratios of 1 (the master clock passed straight through) and every power of two from 2 up to 1024 are offered. The 1024 ratio is a build-time option, and without it the slowest rate is master/512.

The ratio field is a sparse one-hot code: bits 0 to 7 pick the ratios 4 to 512, bit 10 picks pass-through, bit 16 picks 1024, and an empty field means divide-by-2. Every change to the ratio, the enable or the idle condition is applied only at a point where the output is low and a high phase has been completed in full. Software can therefore stop the clock, load a new ratio and restart it without producing a short pulse.

Top module: `card_clk_div`

## Requirements
- R1: After reset the control word reads 0 and the output is low. A write stores only bits 0-7 (ratio ladder), 8 (enable), 9 (auto-stop), 10 (pass-through) and 16 (divide-by-1024, only when that option is built in). All other bits read back as 0.
- R2: With a single ratio bit set, the output period is the master period times: 2^(k+2) for bit k (k = 0..7), 1 for bit 10, 1024 for bit 16. With no ratio bit set, the multiplier is 2.
- R3: When several ratio bits are set, the largest selected divisor applies. Bit 10 counts as divisor 1 and bit 16 as divisor 1024.
- R4: When the output runs, its high phase lasts exactly half the selected period. In pass-through mode it follows the master clock high phase.
- R5: While bit 8 (enable) is 0, the output produces no rising edge and settles low.
- R6: When bit 9 (auto-stop) is 1 and the idle input is high, the output finishes its current high phase and then stays low. It resumes when idle falls. With bit 9 at 0 the idle input has no effect.
- R7: The output never glitches. Every high pulse lasts half a period of a legal ratio, every low pulse lasts at least half a master period, and ratio and enable changes take hold only while the output is low.
- R8: Without the divide-by-1024 option, bit 16 is not stored. A code selecting 1024 with bit 7 then gives master/512, and with no other ratio bit it gives master/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 17 | Control word write data |
| ctl_q | output | 17 | Stored control word |
| bus_idle | input | 1 | High while the transfer engine has no transfer in progress |
| card_clk | output | 1 | Divided, gated card clock |

## Verification
The two functions that can fall in the same cycle are the ratio reload at the end of a low phase and the idle-driven stop. Either one changes whether the next high phase starts. The bench provokes the overlap by writing a new ratio with enable and auto-stop set while idle is already high. It then checks that no rising edge appears until idle drops, and that the first measured period after release belongs to the new ratio. An edge monitor on the output times every high and low pulse over the whole run. A pulse shortened by a badly timed reload is counted as a glitch.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
// ccd_pkg: shared field positions and helpers for the card clock divider.
// Assumes the control word layout decoded by software: ladder bits 0..7,
// enable 8, auto-stop 9, pass-through 10, slowest ratio 16.
package ccd_pkg;
    localparam int CTL_W    = 17;
    localparam int LADDER_N = 8;
    localparam int BIT_EN   = 8;
    localparam int BIT_AUTO = 9;
    localparam int BIT_BYP  = 10;
    localparam int BIT_SLOW = 16;
    localparam int SHIFT_W  = 4;

    // Writable-bit mask of the control word for a given build option.
    function automatic logic [CTL_W-1:0] ctl_mask(input bit has_slow);
        logic [CTL_W-1:0] m;
        m = '0;
        m[LADDER_N-1:0] = '1;
        m[BIT_EN]   = 1'b1;
        m[BIT_AUTO] = 1'b1;
        m[BIT_BYP]  = 1'b1;
        m[BIT_SLOW] = has_slow;
        return m;
    endfunction
endpackage

// File: rtl/ccd_ctl_reg.sv
`timescale 1ns/1ps
// ccd_ctl_reg: control word storage. Keeps only the defined bits.
// Assumes a single-cycle write strobe in the master clock domain.
module ccd_ctl_reg
    import ccd_pkg::*;
#(
    parameter bit HAS_SLOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] q
);
    localparam logic [CTL_W-1:0] MASK = ctl_mask(HAS_SLOW);

    // Capture masked write data; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata & MASK;
    end
endmodule

// File: rtl/ccd_div_decode.sv
`timescale 1ns/1ps
// ccd_div_decode: maps the sparse one-hot ratio field to log2(divisor).
// Higher divisors override lower ones, so an illegal multi-bit code
// resolves to the largest selected ratio. Empty field means shift 1 (/2).
module ccd_div_decode
    import ccd_pkg::*;
(
    input  logic [LADDER_N-1:0] ladder,
    input  logic                byp_sel,
    input  logic                slow_sel,
    output logic [SHIFT_W-1:0]  shift
);
    // Priority decode from smallest to largest divisor.
    always_comb begin
        shift = SHIFT_W'(1);
        if (byp_sel)
            shift = '0;
        for (int k = 0; k < LADDER_N; k++) begin
            if (ladder[k])
                shift = SHIFT_W'(k + 2);
        end
        if (slow_sel)
            shift = SHIFT_W'(LADDER_N + 2);
    end
endmodule

// File: rtl/ccd_clk_gen.sv
`timescale 1ns/1ps
// ccd_clk_gen: produces the card clock. Divided ratios come from a
// half-period counter driving div_q. Pass-through gates the master clock
// with a falling-edge enable. A new ratio and the run decision are taken
// only at the end of a low half, so high phases are never cut short.
// Assumes run_ok and new_shift are stable around the falling edge.
module ccd_clk_gen #(
    parameter int SHIFT_W = 4,
    parameter int CNT_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] new_shift,
    input  logic               run_ok,
    output logic               div_q,
    output logic               pass_gate,
    output logic [SHIFT_W-1:0] act_shift,
    output logic [CNT_W-1:0]   cnt,
    output logic               card_clk
);
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] half_m1;

    // Half period length in master cycles for the active ratio.
    always_comb begin
        half_len = CNT_W'(1) << (act_shift - SHIFT_W'(1));
        half_m1  = half_len - CNT_W'(1);
    end

    // Half-period sequencer for the divided ratios.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_shift <= SHIFT_W'(1);
            div_q     <= 1'b0;
            cnt       <= '0;
        end else if (act_shift == '0) begin
            act_shift <= new_shift;
            div_q     <= 1'b0;
            cnt       <= '0;
        end else if (cnt != half_m1) begin
            cnt <= cnt + CNT_W'(1);
        end else begin
            cnt <= '0;
            if (div_q) begin
                div_q <= 1'b0;
            end else begin
                act_shift <= new_shift;
                div_q     <= run_ok && (new_shift != '0);
            end
        end
    end

    // Pass-through enable, updated only while the master clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n)
            pass_gate <= 1'b0;
        else
            pass_gate <= (act_shift == '0) && run_ok;
    end

    // Both paths are never high together, so an OR merges them cleanly.
    assign card_clk = div_q | (clk & pass_gate);
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
// card_clk_div: card clock divider top. Holds the control word, decodes
// the ratio and drives the glitch-free generator. Assumes bus_idle is
// synchronous to clk.
module card_clk_div
    import ccd_pkg::*;
#(
    parameter bit HAS_DIV1024 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             bus_idle,
    output logic             card_clk
);
    localparam int MAX_SHIFT = HAS_DIV1024 ? (LADDER_N + 2) : (LADDER_N + 1);
    localparam int CNT_W     = MAX_SHIFT;

    logic               slow_sel;
    logic               run_ok;
    logic [SHIFT_W-1:0] new_shift;
    logic [SHIFT_W-1:0] act_shift;
    logic [CNT_W-1:0]   cnt;
    logic               div_q;
    logic               pass_gate;

    ccd_ctl_reg #(.HAS_SLOW(HAS_DIV1024)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .q     (ctl_q)
    );

    // The slowest ratio bit exists only in builds that offer it.
    generate
        if (HAS_DIV1024) begin : g_slow
            assign slow_sel = ctl_q[BIT_SLOW];
        end else begin : g_no_slow
            assign slow_sel = 1'b0;
        end
    endgenerate

    ccd_div_decode u_dec (
        .ladder   (ctl_q[LADDER_N-1:0]),
        .byp_sel  (ctl_q[BIT_BYP]),
        .slow_sel (slow_sel),
        .shift    (new_shift)
    );

    // Clock may run when enabled and not parked by an idle bus.
    assign run_ok = ctl_q[BIT_EN] & ~(ctl_q[BIT_AUTO] & bus_idle);

    ccd_clk_gen #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_shift (new_shift),
        .run_ok    (run_ok),
        .div_q     (div_q),
        .pass_gate (pass_gate),
        .act_shift (act_shift),
        .cnt       (cnt),
        .card_clk  (card_clk)
    );
endmodule

// File: rtl/card_clk_div_chk.sv
`timescale 1ns/1ps
// card_clk_div_chk: temporal checks on the card clock divider, bound to
// the top. Observes the run decision, the generator state and the
// stored control word.
module card_clk_div_chk #(
    parameter bit HAS_DIV1024 = 1'b1,
    parameter int SHIFT_W     = 4,
    parameter int CNT_W       = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               auto_stop,
    input logic               slow_bit,
    input logic               bus_idle,
    input logic               run_ok,
    input logic               div_q,
    input logic               pass_gate,
    input logic [SHIFT_W-1:0] act_shift,
    input logic [CNT_W-1:0]   cnt
);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(1) << (CNT_W - 1);

    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> $past(run_ok)); // R5
    AST_IDLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_stop && bus_idle) |=> !$rose(div_q)); // R6
    AST_SHIFT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        div_q |=> $stable(act_shift)); // R7
    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_q && pass_gate)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_LIM); // R4

    generate
        if (!HAS_DIV1024) begin : g_no_slow_chk
            AST_NO_1024_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                !slow_bit); // R8
        end
    endgenerate
endmodule

bind card_clk_div card_clk_div_chk #(
    .HAS_DIV1024 (HAS_DIV1024),
    .SHIFT_W     (ccd_pkg::SHIFT_W),
    .CNT_W       (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_stop (ctl_q[ccd_pkg::BIT_AUTO]),
    .slow_bit  (ctl_q[ccd_pkg::BIT_SLOW]),
    .bus_idle  (bus_idle),
    .run_ok    (run_ok),
    .div_q     (div_q),
    .pass_gate (pass_gate),
    .act_shift (act_shift),
    .cnt       (cnt)
);

// File: tb/test_card_clk_div.sv
`timescale 1ns/1ps
// test_card_clk_div: directed corners plus seeded random ratio codes,
// checked by timing the card clock edges against computed expectations.
module test_card_clk_div;
    localparam logic [16:0] EN   = 17'h00100;
    localparam logic [16:0] AUTO = 17'h00200;
    localparam logic [16:0] BYP  = 17'h00400;
    localparam logic [16:0] SLOW = 17'h10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [16:0] ctl_wdata = '0;
    logic        bus_idle = 1'b0;
    logic [16:0] q_a, q_b;
    logic        ck_a, ck_b;

    int     n_chk = 0, n_bad = 0;
    int     rises_a = 0, glitches = 0;
    longint t_rise_a = 0, t_fall_a = 0;
    bit     seen_rise = 0, seen_fall = 0;

    always #5 clk = ~clk;

    card_clk_div #(.HAS_DIV1024(1'b1)) i_card_clk_div (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(q_a), .bus_idle(bus_idle), .card_clk(ck_a));

    card_clk_div #(.HAS_DIV1024(1'b0)) i_card_clk_div_n1024 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(q_b), .bus_idle(bus_idle), .card_clk(ck_b));

    function automatic int exp_div(input logic [16:0] c, input bit has);
        int d = 2;
        if (c[10]) d = 1;
        for (int k = 0; k < 8; k++) if (c[k]) d = 1 << (k + 2);
        if (has && c[16]) d = 1024;
        return d;
    endfunction

    function automatic logic [16:0] exp_mask(input bit has);
        return has ? 17'h107FF : 17'h007FF;
    endfunction

    function automatic bit legal_high(input longint w);
        for (int k = 0; k <= 10; k++) if (w == 5 * (longint'(1) << k)) return 1'b1;
        return 1'b0;
    endfunction

    // R7 edge monitor: every pulse must have a legal width.
    always @(posedge ck_a) begin
        rises_a++;
        if (seen_fall && ($time - t_fall_a) < 5) glitches++;
        t_rise_a = $time;
        seen_rise = 1'b1;
    end
    always @(negedge ck_a) begin
        if (seen_rise) begin
            if (!legal_high($time - t_rise_a)) glitches++;
            t_fall_a = $time;
            seen_fall = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [16:0] v);
        @(posedge clk); #2;
        ctl_we = 1'b1; ctl_wdata = v;
        @(posedge clk); #2;
        ctl_we = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Stop, reload, restart: the sequence software uses.
    task automatic set_div(input logic [16:0] code);
        wr(q_a & ~EN);
        wr(code & ~EN);
        wr(code | EN);
    endtask

    task automatic measure(input bit on_b, input int dexp, input string req);
        longint t1, t2, t3;
        if (!on_b) begin
            repeat (2) @(posedge ck_a);
            @(posedge ck_a); t1 = $time;
            @(negedge ck_a); t2 = $time;
            @(posedge ck_a); t3 = $time;
        end else begin
            repeat (2) @(posedge ck_b);
            @(posedge ck_b); t1 = $time;
            @(negedge ck_b); t2 = $time;
            @(posedge ck_b); t3 = $time;
        end
        check(t3 - t1 == 10 * dexp, req, t3 - t1, 10 * dexp);
        check(t2 - t1 == 5 * dexp, "R4 high phase", t2 - t1, 5 * dexp);
    endtask

    task automatic expect_quiet(input string req);
        wait_clk(20);
        rises_a = 0;
        wait_clk(60);
        check(rises_a == 0, req, rises_a, 0);
        check(ck_a == 1'b0, req, ck_a, 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [16:0] v;
        void'($urandom(32'd20240611));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 reset state, R5 disabled after reset
        check(q_a == '0, "R1 reset word", q_a, 0);
        expect_quiet("R5 no edge after reset");

        // R1 and R8 masked readback with random data, enable kept off
        for (int i = 0; i < 6; i++) begin
            v = 17'($urandom) & ~EN;
            wr(v);
            check(q_a == (v & exp_mask(1'b1)), "R1 readback", q_a, v & exp_mask(1'b1));
            check(q_b == (v & exp_mask(1'b0)), "R8 readback no slow bit", q_b, v & exp_mask(1'b0));
        end

        // R2 single ratio bits on the ladder
        for (int k = 0; k < 8; k++) begin
            set_div(17'(1) << k);
            measure(1'b0, 1 << (k + 2), "R2 ladder period");
        end
        set_div('0);      measure(1'b0, 2, "R2 empty field /2");
        set_div(BYP);     measure(1'b0, 1, "R2 pass-through");
        set_div(SLOW);    measure(1'b0, 1024, "R2 slow /1024");
        measure(1'b1, 2, "R8 slow bit ignored gives /2");

        // R3 multi-bit codes resolve to the largest divisor
        set_div(17'h00012);        measure(1'b0, 64, "R3 bits 1 and 4");
        set_div(BYP | 17'h00004);  measure(1'b0, 16, "R3 pass plus bit 2");
        set_div(SLOW | 17'h00080); measure(1'b0, 1024, "R3 slow plus bit 7");
        measure(1'b1, 512, "R8 slowest without option is /512");

        // R5 disable parks the output
        set_div(17'h00002);
        measure(1'b0, 8, "R2 /8 before disable");
        wr(q_a & ~EN);
        expect_quiet("R5 disabled no edge");

        // R6 auto-stop on idle, and idle ignored without auto-stop
        set_div(17'h00002 | AUTO);
        measure(1'b0, 8, "R6 auto-stop busy bus runs");
        @(posedge clk); #2 bus_idle = 1'b1;
        expect_quiet("R6 idle parks clock");
        @(posedge clk); #2 bus_idle = 1'b0;
        measure(1'b0, 8, "R6 resumes after idle");
        @(posedge clk); #2 bus_idle = 1'b1;
        set_div(17'h00002);
        measure(1'b0, 8, "R6 idle ignored without auto-stop");
        set_div(BYP | AUTO);
        expect_quiet("R6 pass-through parked by idle");

        // R6/R7 overlap: new ratio written while idle holds the clock
        set_div(17'h00008 | AUTO);
        expect_quiet("R6 reload under idle stays low");
        @(posedge clk); #2 bus_idle = 1'b0;
        measure(1'b0, 32, "R7 new ratio after idle release");

        // R2/R3 random codes on the ladder and pass-through bits
        for (int i = 0; i < 10; i++) begin
            v = '0;
            for (int k = 0; k < 8; k++) if ($urandom % 6 == 0) v[k] = 1'b1;
            if ($urandom % 8 == 0) v[10] = 1'b1;
            if ($urandom % 2 == 0) v = v | AUTO;
            set_div(v);
            measure(1'b0, exp_div(v, 1'b1), "R3 random code period");
        end

        // R7 no pulse of illegal width anywhere in the run
        check(glitches == 0, "R7 glitch-free output", glitches, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule